// File: doc/BRIEF.md
# Numeric Window to Ternary Word Expander

This block turns one inclusive numeric window, called a road here, into the short list of ternary words (a value and a don't-care mask) that a ternary match memory needs to recognise every number in that window and nothing else. Each word covers an aligned block whose size is a power of two: the high-order bits are fixed and the low-order bits are don't-cares. The list is produced by a greedy walk from the low end of the window. Each step takes the largest aligned block that starts at the current value and stays at or below the upper end.

A road arrives as a packed word together with a road index. Each index owns a fixed group of consecutive match-memory slots. The block first walks the window once without writing anything, to count the words it needs. If the window is empty or needs more words than a group holds, the block writes nothing and flags an error. Otherwise it streams the words into the group one per cycle in ascending order. It then fills the rest of the group with entries marked not-live, and signals completion.

Top module: `range_prefix_expander`

## Requirements
- R1: The road word carries the upper bound in bits [21:11] and the lower bound in bits [10:0]. Both bounds are inclusive, and the block covers every value in between.
- R2: On each write, a mask bit of 1 marks a don't-care bit. The mask of a live entry is a run of ones starting from bit 0, and the value has zeros in every masked position.
- R3: Live entries come out in ascending order with no gaps: the first covers the lower bound, and each later one starts one past the end of the previous one. Each is the largest aligned block that starts at its value and does not pass the upper bound, and the last one ends exactly on the upper bound.
- R4: The write address is road_index*12 + slot. Slots count up from 0 by one per write, and a successful road always fills slots 0 through 11.
- R5: Slots beyond the last live word are written with wr_live=0, value 0 and mask 0. They are never followed by a live entry in the same road.
- R6: If the lower bound is greater than the upper bound, no write occurs. Done then pulses with err=1 and word_cnt=0.
- R7: If the window needs more than 12 words, no write occurs. Done then pulses with err=1 and word_cnt=0. A window that needs exactly 12 words succeeds.
- R8: Done is high for exactly one cycle, in the cycle after the final write. On success err=0 there, and word_cnt equals the number of live entries.
- R9: Busy rises in the cycle after a start is accepted and stays high up to and including the done cycle. A start raised while busy is ignored and causes no writes.
- R10: After reset, busy, done, err and wr_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a road; accepted only when not busy |
| road_word | input | 22 | Upper bound [21:11], lower bound [10:0] |
| road_idx | input | 6 | Road index selecting the slot group |
| busy | output | 1 | Road in progress |
| wr_en | output | 1 | Write strobe toward the match memory |
| wr_addr | output | 10 | Slot address of the write |
| wr_value | output | 11 | Ternary word value |
| wr_mask | output | 11 | Don't-care mask, 1 = ignore bit |
| wr_live | output | 1 | Entry is valid (0 for unused slots) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Road rejected, qualified by done |
| word_cnt | output | 4 | Live words written, qualified by done |

## Verification
The ordering and upper-bound properties assume that the bounds latched at start stay fixed for the whole road. They also assume that reset is held long enough for every register to reach its idle value. The bench drives start only on the falling edge, keeps road_word and road_idx steady around each accepted start, and deliberately raises a second start while busy to confirm that it is ignored. Its windows include single values, the full range, windows of exactly 12 words, windows that need more than 12 words, reversed bounds, and the highest road index.

// File: rtl/rpx_pkg.sv
package rpx_pkg;
   typedef enum logic [2:0] {
      RPX_IDLE = 3'd0,
      RPX_SCAN = 3'd1,
      RPX_EMIT = 3'd2,
      RPX_PAD  = 3'd3,
      RPX_DONE = 3'd4
   } rpx_state_e;
endpackage

// File: rtl/rpx_block_picker.sv
// Largest aligned power-of-two block starting at cur and ending at or below hi.
module rpx_block_picker #(
   parameter int VAL_W = 11,
   localparam int W    = VAL_W + 1,
   localparam int K_W  = $clog2(VAL_W + 1)
) (
   input  logic [W-1:0]     cur,
   input  logic [W-1:0]     hi,
   output logic [VAL_W-1:0] blk_mask,
   output logic [W-1:0]     nxt
);
   logic [VAL_W:0] fits;
   logic [K_W-1:0] pick;
   logic [W-1:0]   span;

   for (genvar k = 0; k <= VAL_W; k++) begin : g_fit
      localparam logic [W-1:0] LOWM = (W'(1) << k) - W'(1);
      assign fits[k] = ((cur & LOWM) == '0) && ((cur | LOWM) <= hi);
   end

   always_comb begin
      pick = '0;
      for (int k = 0; k <= VAL_W; k++) begin
         if (fits[k]) pick = K_W'(k);
      end
   end

   assign span     = (W'(1) << pick) - W'(1);
   assign blk_mask = span[VAL_W-1:0];
   assign nxt      = cur + span + W'(1);
endmodule

// File: rtl/rpx_addr_gen.sv
// Slot address inside the group owned by a road.
module rpx_addr_gen #(
   parameter int IDX_W  = 6,
   parameter int SLOTS  = 12,
   parameter int SLOT_W = 4,
   parameter int ADDR_W = 10
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [SLOT_W-1:0] slot,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] base;
   assign base = ADDR_W'(idx) * ADDR_W'(SLOTS);
   assign addr = base + ADDR_W'(slot);
endmodule

// File: rtl/range_prefix_expander.sv
module range_prefix_expander
   import rpx_pkg::*;
#(
   parameter int VAL_W      = 11,
   parameter int IDX_W      = 6,
   parameter int SLOTS      = 12,
   parameter bit PAD_UNUSED = 1'b1,
   localparam int ADDR_W    = $clog2((1 << IDX_W) * SLOTS),
   localparam int CNT_W     = $clog2(SLOTS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [2*VAL_W-1:0]  road_word,
   input  logic [IDX_W-1:0]    road_idx,
   output logic                busy,
   output logic                wr_en,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [VAL_W-1:0]    wr_value,
   output logic [VAL_W-1:0]    wr_mask,
   output logic                wr_live,
   output logic                done,
   output logic                err,
   output logic [CNT_W-1:0]    word_cnt
);
   localparam int W = VAL_W + 1;

   if (VAL_W < 2 || VAL_W > 24) begin : g_bad_width
      $error("range_prefix_expander: VAL_W out of range");
   end
   if (SLOTS < 1) begin : g_bad_slots
      $error("range_prefix_expander: SLOTS must be positive");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("range_prefix_expander: IDX_W must be positive");
   end

   rpx_state_e        state_q;
   logic [W-1:0]      lo_q, hi_q, cur_q;
   logic [IDX_W-1:0]  idx_q;
   logic [CNT_W-1:0]  cnt_q, slot_q, total_q;
   logic              err_q;

   logic [VAL_W-1:0]  blk_mask;
   logic [W-1:0]      nxt;
   logic              last_blk;
   logic [CNT_W-1:0]  cnt_inc;
   logic              pad_more;
   logic [W-1:0]      in_lo, in_hi;

   assign in_lo = {1'b0, road_word[VAL_W-1:0]};
   assign in_hi = {1'b0, road_word[2*VAL_W-1:VAL_W]};

   rpx_block_picker #(.VAL_W(VAL_W)) u_picker (
      .cur      (cur_q),
      .hi       (hi_q),
      .blk_mask (blk_mask),
      .nxt      (nxt)
   );

   rpx_addr_gen #(
      .IDX_W (IDX_W), .SLOTS (SLOTS), .SLOT_W (CNT_W), .ADDR_W (ADDR_W)
   ) u_addr (
      .idx  (idx_q),
      .slot (slot_q),
      .addr (wr_addr)
   );

   assign last_blk = (nxt > hi_q);
   assign cnt_inc  = cnt_q + CNT_W'(1);

   if (PAD_UNUSED) begin : g_pad
      assign pad_more = (slot_q + CNT_W'(1)) < CNT_W'(SLOTS);
   end else begin : g_nopad
      assign pad_more = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RPX_IDLE;
         lo_q    <= '0;
         hi_q    <= '0;
         cur_q   <= '0;
         idx_q   <= '0;
         cnt_q   <= '0;
         slot_q  <= '0;
         total_q <= '0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            RPX_IDLE: begin
               if (start) begin
                  lo_q    <= in_lo;
                  hi_q    <= in_hi;
                  cur_q   <= in_lo;
                  idx_q   <= road_idx;
                  cnt_q   <= '0;
                  slot_q  <= '0;
                  total_q <= '0;
                  if (in_lo > in_hi) begin
                     err_q   <= 1'b1;
                     state_q <= RPX_DONE;
                  end else begin
                     err_q   <= 1'b0;
                     state_q <= RPX_SCAN;
                  end
               end
            end
            RPX_SCAN: begin
               if (last_blk) begin
                  total_q <= cnt_inc;
                  cur_q   <= lo_q;
                  slot_q  <= '0;
                  state_q <= RPX_EMIT;
               end else if (cnt_inc == CNT_W'(SLOTS)) begin
                  err_q   <= 1'b1;
                  state_q <= RPX_DONE;
               end else begin
                  cur_q <= nxt;
                  cnt_q <= cnt_inc;
               end
            end
            RPX_EMIT: begin
               cur_q  <= nxt;
               slot_q <= slot_q + CNT_W'(1);
               if (last_blk) begin
                  state_q <= pad_more ? RPX_PAD : RPX_DONE;
               end
            end
            RPX_PAD: begin
               slot_q <= slot_q + CNT_W'(1);
               if (!pad_more) state_q <= RPX_DONE;
            end
            RPX_DONE: begin
               state_q <= RPX_IDLE;
            end
            default: state_q <= RPX_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != RPX_IDLE);
   assign wr_en    = (state_q == RPX_EMIT) || (state_q == RPX_PAD);
   assign wr_live  = (state_q == RPX_EMIT);
   assign wr_value = wr_live ? cur_q[VAL_W-1:0] : '0;
   assign wr_mask  = wr_live ? blk_mask : '0;
   assign done     = (state_q == RPX_DONE);
   assign err      = done && err_q;
   assign word_cnt = (done && !err_q) ? total_q : '0;

   // Assertions
   assert_mask_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_live) |-> ((({1'b0, wr_mask} + W'(1)) & {1'b0, wr_mask}) == '0));

   assert_value_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_live) |-> ((wr_value & wr_mask) == '0));

   assert_within_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_live) |-> ({1'b0, wr_value | wr_mask} <= hi_q));

   assert_no_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_live && $past(wr_en && wr_live))
      |-> ({1'b0, wr_value} == $past({1'b0, wr_value | wr_mask}) + W'(1)));

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

   assert_pad_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_live) |=> !(wr_en && wr_live));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_en);

   assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
endmodule

// File: tb/range_prefix_expander_bench.sv
`timescale 1ns/1ps
module range_prefix_expander_bench;
   typedef struct packed {
      logic [9:0]  addr;
      logic [10:0] val;
      logic [10:0] msk;
      logic        live;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [21:0] road_word = '0;
   logic [5:0]  road_idx = '0;
   logic        busy, wr_en, wr_live, done, err;
   logic [9:0]  wr_addr;
   logic [10:0] wr_value, wr_mask;
   logic [3:0]  word_cnt;

   int   checks = 0;
   int   fails  = 0;
   exp_t q[$];
   bit   exp_bad = 1'b0;
   bit   prev_wr = 1'b0;
   bit   finished = 1'b0;

   always #2 clk = ~clk;

   range_prefix_expander u_range_prefix_expander (
      .clk, .rst_n, .start, .road_word, .road_idx, .busy, .wr_en,
      .wr_addr, .wr_value, .wr_mask, .wr_live, .done, .err, .word_cnt
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard on every write, checks done timing.
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) begin
            if (q.size() == 0) begin
               check(1'b0, "R9 unexpected write (R6/R7)", int'(wr_addr), -1);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(wr_addr == e.addr, "R4 address", int'(wr_addr), int'(e.addr));
               check(wr_live == e.live, "R5 live flag", int'(wr_live), int'(e.live));
               check(wr_value == e.val, e.live ? "R3 value" : "R5 pad value",
                     int'(wr_value), int'(e.val));
               check(wr_mask == e.msk, e.live ? "R2 mask" : "R5 pad mask",
                     int'(wr_mask), int'(e.msk));
            end
         end
         if (done) check(prev_wr == !exp_bad, "R8 done follows last write",
                         int'(prev_wr), int'(!exp_bad));
         prev_wr = wr_en;
      end
   end

   // Expected words from R1..R7: greedy aligned blocks, then padding.
   task automatic run_road(input int lo, input int hi, input int idx, input bit poke);
      exp_t tmp[$];
      int   n = 0;
      bit   bad;
      bit   seen;
      bad = (lo > hi);
      if (!bad) begin
         int v = lo;
         while (v <= hi) begin
            int k = 11;
            while (k > 0 && (((v % (1 << k)) != 0) || (v + (1 << k) - 1 > hi))) k--;
            tmp.push_back('{addr: 10'(idx * 12 + n), val: 11'(v),
                            msk: 11'((1 << k) - 1), live: 1'b1});
            v += (1 << k);
            n++;
         end
         if (n > 12) bad = 1'b1;
      end
      exp_bad = bad;
      if (!bad) begin
         foreach (tmp[i]) q.push_back(tmp[i]);
         for (int s = n; s < 12; s++)
            q.push_back('{addr: 10'(idx * 12 + s), val: '0, msk: '0, live: 1'b0});
      end
      @(negedge clk);
      road_word = {11'(hi), 11'(lo)};
      road_idx  = 6'(idx);
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
      if (poke) begin
         @(negedge clk);
         road_word = {11'd3, 11'd0};
         road_idx  = 6'd5;
         start     = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      seen = 1'b0;
      for (int c = 0; c < 200 && !seen; c++) begin
         if (done) seen = 1'b1;
         else begin
            check(busy == 1'b1, "R9 busy until done", int'(busy), 1);
            @(negedge clk);
         end
      end
      check(seen, "R8 done reached", int'(seen), 1);
      check(err == bad, bad ? "R6/R7 err flag" : "R8 err clear", int'(err), int'(bad));
      check(word_cnt == (bad ? 0 : n), bad ? "R7 count zero" : "R8 word count",
            int'(word_cnt), bad ? 0 : n);
      check(busy == 1'b1, "R9 busy in done cycle", int'(busy), 1);
      check(q.size() == 0, "R4 all slots written", q.size(), 0);
      @(negedge clk);
      check(done == 1'b0, "R8 done one cycle", int'(done), 0);
      check(busy == 1'b0, "R9 idle after done", int'(busy), 0);
      repeat (3) @(negedge clk);
      check(q.size() == 0, "R9 no stray writes", q.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0 && err == 0 && wr_en == 0, "R10 reset state",
            int'({busy, done, err, wr_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_road(5, 5, 0, 1'b0);       // R1 single value
      run_road(0, 2047, 1, 1'b0);    // R2 full range, one word
      run_road(8, 15, 2, 1'b1);      // R9 start ignored while busy
      run_road(3, 17, 3, 1'b0);      // R3 unaligned both ends
      run_road(1, 126, 4, 1'b0);     // R7 exactly 12 words
      run_road(1, 254, 5, 1'b0);     // R7 needs 14 words
      run_road(1, 2046, 6, 1'b0);    // R7 worst case
      run_road(10, 4, 7, 1'b0);      // R6 reversed bounds
      run_road(2047, 2047, 63, 1'b0);// R4 top index, top value
      run_road(0, 0, 9, 1'b0);       // R1 zero
      run_road(1000, 1500, 10, 1'b0);// R3 mid range
      run_road(1024, 2047, 62, 1'b0);// R2 upper half
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule